// File: doc/BRIEF.md
# Brownout Reset and Interrupt Controller

This block turns a supply-low comparator signal into one of two system actions. The comparator output arrives asynchronously. It is resynchronized, and its synchronized level drives the rest of the logic. A mode input selects the action.

With the mode input low, the block requests a processor reset for as long as the supply stays low. With the mode input high, each new low-going supply crossing latches one pending interrupt. That interrupt reaches the processor only while both the global enable and the brownout enable are set. Either mode also sets a cause flag. The flag survives the reset it triggers and is cleared only by software.

The block's own `rst_n` is the power-on reset. The `rst_req` output is what the block drives into the processor's reset tree.

Top module: `brownout_ctl`

## Requirements
- R1: After `rst_n` is released, `rst_req`, `irq_req` and `bo_flag` are all 0 until the comparator input rises.
- R2: With `irq_mode`=0, `rst_req` goes to 1 two clock edges after `vlow_raw` goes high. It stays at 1 while the synchronized level stays high and falls two edges after `vlow_raw` falls.
- R3: With `irq_mode`=0, a brownout never makes an interrupt pending, so `irq_req` stays 0 even with both enables set.
- R4: With `irq_mode`=1, `rst_req` is 0 at all times.
- R5: With `irq_mode`=1, a low-going crossing is the synchronized level going from 0 to 1. Each such crossing makes the interrupt pending exactly once, three edges after `vlow_raw` rises. No new pending bit is set while the level stays high.
- R6: `irq_req` is 1 exactly when the interrupt is pending and both `gie` and `bie` are 1. A crossing seen while either enable is 0 is still recorded as pending.
- R7: `irq_ack` clears the pending interrupt on the next edge. If a new crossing arrives in the same cycle as the acknowledge, the interrupt stays pending.
- R8: Every crossing sets `bo_flag` in either mode, and `bo_flag` stays 1 until `flag_clr` is sampled high.
- R9: When `flag_clr` and a new crossing occur in the same cycle, `bo_flag` is set and not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| vlow_raw | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| irq_mode | input | 1 | 0 = reset action, 1 = interrupt action |
| gie | input | 1 | Global interrupt enable |
| bie | input | 1 | Brownout interrupt enable |
| irq_ack | input | 1 | Clears the pending interrupt |
| flag_clr | input | 1 | Clears the cause flag |
| rst_req | output | 1 | Processor reset request |
| irq_req | output | 1 | Enabled pending interrupt |
| bo_flag | output | 1 | Sticky brownout cause flag |

## Verification
Long low pulses in reset mode show that the reset request is held for the whole low period and is not a pulse. The same pulses in interrupt mode show that only one interrupt is produced per crossing. Crossings made with the enables off and then turned on separate recording a crossing from delivering it. Acknowledges and flag clears that coincide with a new crossing separate set-priority from clear-priority. A long stretch of random comparator, mode, enable and strobe activity is then compared every cycle against a behavioural model.

// File: rtl/brownout_ctl.sv
module brownout_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow_raw,
  input  logic irq_mode,
  input  logic gie,
  input  logic bie,
  input  logic irq_ack,
  input  logic flag_clr,
  output logic rst_req,
  output logic irq_req,
  output logic bo_flag
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic low_d;
  logic pend_q;
  logic flag_q;
  logic low;
  logic drop;

  assign low  = sync_q[SYNC_STAGES-1];
  assign drop = low & ~low_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      low_d  <= 1'b0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], vlow_raw};
      low_d  <= low;
      pend_q <= (pend_q & ~irq_ack) | (drop & irq_mode);
      flag_q <= (flag_q & ~flag_clr) | drop;
    end
  end

  assign rst_req = low & ~irq_mode;
  assign irq_req = pend_q & gie & bie;
  assign bo_flag = flag_q;

endmodule

module brownout_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_mode,
  input logic gie,
  input logic bie,
  input logic irq_ack,
  input logic flag_clr,
  input logic rst_req,
  input logic irq_req,
  input logic bo_flag
);

  AST_RST_ONLY_IN_RESET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !irq_mode); // R4

  AST_IRQ_NEEDS_BOTH_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && bie)); // R6

  AST_NO_IRQ_IN_RESET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode && !irq_req && gie && bie) |=> !irq_req || $changed(gie) || $changed(bie) || $past(irq_mode) != irq_mode); // R3

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && $stable(gie) && $stable(bie)) |=> (irq_req || !gie || !bie)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_flag && !flag_clr) |=> bo_flag); // R8

  AST_RESET_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_req) && $stable(irq_mode)) |=> bo_flag); // R8

endmodule

bind brownout_ctl brownout_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode), .gie(gie), .bie(bie),
  .irq_ack(irq_ack), .flag_clr(flag_clr), .rst_req(rst_req),
  .irq_req(irq_req), .bo_flag(bo_flag)
);

// File: tb/sim_brownout_ctl.sv
module sim_brownout_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vlow_raw = 1'b0, irq_mode = 1'b0, gie = 1'b0, bie = 1'b0;
  logic irq_ack = 1'b0, flag_clr = 1'b0;
  logic rst_req, irq_req, bo_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  brownout_ctl #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .vlow_raw(vlow_raw), .irq_mode(irq_mode),
    .gie(gie), .bie(bie), .irq_ack(irq_ack), .flag_clr(flag_clr),
    .rst_req(rst_req), .irq_req(irq_req), .bo_flag(bo_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  bit hist[$];
  bit m_low, m_prev, m_pend, m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      m_low = 0; m_prev = 0; m_pend = 0; m_flag = 0;
    end else begin
      bit crossing;
      crossing = m_low && !m_prev;
      if (crossing && irq_mode) m_pend = 1;
      else if (irq_ack) m_pend = 0;
      if (crossing) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_prev = m_low;
      hist.push_back(vlow_raw);
      if (hist.size() > SYNC) void'(hist.pop_front());
      m_low = (hist.size() == SYNC) ? hist[0] : 1'b0;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "rst_req vs model", rst_req, m_low && !irq_mode);
      chk("R6", "irq_req vs model", irq_req, m_pend && gie && bie);
      chk("R8", "bo_flag vs model", bo_flag, m_flag);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", "rst_req after reset", rst_req, 1'b0);
    chk("R1", "irq_req after reset", irq_req, 1'b0);
    chk("R1", "bo_flag after reset", bo_flag, 1'b0);

    gie = 1; bie = 1; irq_mode = 0;
    vlow_raw = 1;
    cyc(1); chk("R2", "rst_req after one edge", rst_req, 1'b0);
    cyc(1); chk("R2", "rst_req after two edges", rst_req, 1'b1);
    cyc(6); chk("R2", "rst_req held while low", rst_req, 1'b1);
    chk("R3", "no irq in reset mode", irq_req, 1'b0);
    chk("R8", "flag set by reset-mode crossing", bo_flag, 1'b1);
    vlow_raw = 0;
    cyc(1); chk("R2", "rst_req one edge after release", rst_req, 1'b1);
    cyc(1); chk("R2", "rst_req released", rst_req, 1'b0);
    cyc(3); chk("R8", "flag sticky after release", bo_flag, 1'b1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R8", "flag cleared", bo_flag, 1'b0);

    irq_mode = 1;
    vlow_raw = 1;
    cyc(2); chk("R5", "no irq after two edges", irq_req, 1'b0);
    chk("R4", "no reset in irq mode", rst_req, 1'b0);
    cyc(1); chk("R5", "irq after three edges", irq_req, 1'b1);
    irq_ack = 1; cyc(1); irq_ack = 0;
    chk("R7", "ack clears", irq_req, 1'b0);
    cyc(10); chk("R5", "no second irq while low", irq_req, 1'b0);
    chk("R4", "still no reset", rst_req, 1'b0);
    vlow_raw = 0; cyc(4);
    flag_clr = 1; cyc(1); flag_clr = 0;

    gie = 0; bie = 1;
    vlow_raw = 1; cyc(5);
    chk("R6", "masked by gie", irq_req, 1'b0);
    gie = 1; bie = 0; cyc(1);
    chk("R6", "masked by bie", irq_req, 1'b0);
    bie = 1; cyc(1);
    chk("R6", "pending delivered on enable", irq_req, 1'b1);
    vlow_raw = 0; cyc(4);
    irq_ack = 1; cyc(1);
    chk("R7", "ack with no crossing", irq_req, 1'b0);

    vlow_raw = 1; flag_clr = 1;
    cyc(3);
    chk("R7", "crossing beats ack", irq_req, 1'b1);
    chk("R9", "crossing beats flag clear", bo_flag, 1'b1);
    cyc(1);
    chk("R7", "held ack clears next cycle", irq_req, 1'b0);
    chk("R9", "held clear clears next cycle", bo_flag, 1'b0);
    irq_ack = 0; flag_clr = 0;
    vlow_raw = 0; cyc(4);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 12) vlow_raw = ~vlow_raw;
      if ($urandom_range(0, 49) == 0) irq_mode = ~irq_mode;
      gie = ($urandom_range(0, 9) != 0);
      bie = ($urandom_range(0, 9) != 0);
      irq_ack = ($urandom_range(0, 7) == 0);
      flag_clr = ($urandom_range(0, 11) == 0);
      cyc(1);
    end
    finish_run();
  end

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule